// File: doc/BRIEF.md
# Multi-lane receive alignment sequencer

This controller runs the phase and delay alignment procedure for a group of serial receiver lanes after a receiver reset or a change of receive rate. Lane 0 is the master; the other lanes are slaves. The sequencer waits for the link to be usable: at least one lane out of electrical idle and clock recovery locked on every lane. It then drives a short delay-reset pulse to all lanes at once and waits until every lane reports that its reset is done. Finally it waits for the master's sync-done indication to rise.

At that rising edge the master's phase-align-done level is captured as the final status. The block then reports done together with either aligned or failed, and holds that result. Delay alignment keeps tracking drift on its own from that point, so the sequencer does not issue another reset until it receives an external restart. Each wait state has a timeout that leads to a latched fault. If lock is lost or all lanes fall back to idle partway through, the sequence is abandoned and starts over from the idle wait.

Top module: `rx_align_seq`

## Requirements
- R1: While reset is applied and right after it, `lane_dly_rst`, `done`, `aligned` and `failed` are all low.
- R2: A delay-reset pulse starts only when `lane_lock` is all ones and `lane_idle` is not all ones. It begins in the cycle after these inputs are first sampled true in the idle wait.
- R3: Every bit of `lane_dly_rst` is high in the same cycles. The pulse lasts max(1, min(RST_CYC, floor(49 / CLK_NS))) cycles, which keeps it under 50 ns whenever the clock period is below 50 ns.
- R4: After the pulse, the sequencer waits until `lane_rst_done` is all ones. A master sync-done edge that arrives before then is ignored.
- R5: Once all lanes report reset done, a rising edge of `m_sync_done` makes `done` high in the next cycle.
- R6: `aligned` and `failed` show the value of `m_phalign_done` sampled at that sync-done rising edge: `aligned` = 1 if it was high, `failed` = 1 if it was low. Later changes of `m_phalign_done` have no effect.
- R7: While `done` is high, no delay-reset is issued and `done` stays high, whatever the lane inputs do, until `restart` is asserted.
- R8: `restart`, asserted in any state, clears `done`, `aligned` and `failed` and returns the sequencer to the idle wait, so that the whole sequence runs again.
- R9: If the sequencer stays TMO_CYC cycles in the reset-done wait or the sync-done wait, it enters a fault state. There `failed` = 1 and `done` = 0 until `restart`.
- R10: If any lane loses lock, or all lanes return to idle, during the pulse or either wait, the sequencer drops the pulse and returns to the idle wait. A later sync-done edge then does not complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Re-run request after a receiver reset or rate change |
| lane_idle | input | LANES | Per-lane electrical-idle indication |
| lane_lock | input | LANES | Per-lane clock-recovery lock |
| lane_rst_done | input | LANES | Per-lane delay-reset done |
| m_sync_done | input | 1 | Master lane sync-done |
| m_phalign_done | input | 1 | Master lane phase-align-done |
| lane_dly_rst | output | LANES | Delay-reset pulse to every lane (bit 0 master) |
| done | output | 1 | Sequence completed |
| aligned | output | 1 | Completed with alignment held |
| failed | output | 1 | Completed without alignment, or timed out |

## Verification
The hardest situation to reach is a master sync-done edge that arrives while the slaves are still in reset, or just after an abort. Both need the sequencer to be in a specific wait state at the moment the edge comes. Directed runs reach them by holding one slave's reset-done low, or by dropping one lane's lock in the sync wait, and then pulsing sync-done. Random idle and lock masks, with lock biased toward all ones, are applied after each restart to exercise the start gate.

// File: rtl/rx_align_seq.sv
`timescale 1ns/1ps
module rx_align_seq #(
  parameter int LANES   = 4,
  parameter int CLK_NS  = 20,
  parameter int RST_CYC = 2,
  parameter int TMO_CYC = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [LANES-1:0] lane_idle,
  input  logic [LANES-1:0] lane_lock,
  input  logic [LANES-1:0] lane_rst_done,
  input  logic             m_sync_done,
  input  logic             m_phalign_done,
  output logic [LANES-1:0] lane_dly_rst,
  output logic             done,
  output logic             aligned,
  output logic             failed
);
  localparam int LIM_CYC = 49 / CLK_NS;
  localparam int PC0     = (RST_CYC < LIM_CYC) ? RST_CYC : LIM_CYC;
  localparam int PULSE_C = (PC0 < 1) ? 1 : PC0;
  localparam int CW      = $clog2(TMO_CYC + PULSE_C + 1);

  typedef enum logic [2:0] {S_IDLE, S_PULSE, S_RDONE, S_SYNC, S_DONE, S_FAULT} st_t;

  st_t st, st_n;
  logic [CW-1:0] cnt;
  logic sync_q, stat_q;
  logic go_ok, sync_rise, tmo, pulse_end;

  assign go_ok     = (~&lane_idle) & (&lane_lock);
  assign sync_rise = m_sync_done & ~sync_q;
  assign tmo       = (cnt == CW'(TMO_CYC - 1));
  assign pulse_end = (cnt == CW'(PULSE_C - 1));

  always_comb begin
    st_n = st;
    if (restart) st_n = S_IDLE;
    else begin
      case (st)
        S_IDLE:  if (go_ok) st_n = S_PULSE;
        S_PULSE: if (!go_ok) st_n = S_IDLE;
                 else if (pulse_end) st_n = S_RDONE;
        S_RDONE: if (!go_ok) st_n = S_IDLE;
                 else if (&lane_rst_done) st_n = S_SYNC;
                 else if (tmo) st_n = S_FAULT;
        S_SYNC:  if (!go_ok) st_n = S_IDLE;
                 else if (sync_rise) st_n = S_DONE;
                 else if (tmo) st_n = S_FAULT;
        default: st_n = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      sync_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      st     <= st_n;
      sync_q <= m_sync_done;
      if (st_n != st) cnt <= '0;
      else if (!tmo) cnt <= cnt + 1'b1;
      if (st == S_SYNC && st_n == S_DONE) stat_q <= m_phalign_done;
    end
  end

  assign lane_dly_rst = {LANES{st == S_PULSE}};
  assign done         = (st == S_DONE);
  assign aligned      = done & stat_q;
  assign failed       = (st == S_FAULT) | (done & ~stat_q);
endmodule

module rx_align_seq_chk #(
  parameter int LANES  = 4,
  parameter int CLK_NS = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             restart,
  input logic [LANES-1:0] lane_idle,
  input logic [LANES-1:0] lane_lock,
  input logic [LANES-1:0] lane_dly_rst,
  input logic             m_sync_done,
  input logic             done,
  input logic             failed
);
  logic [7:0] pw;
  always_ff @(posedge clk) begin
    if (!rst_n) pw <= '0;
    else if (lane_dly_rst[0]) pw <= (pw == 8'hff) ? pw : pw + 8'd1;
    else pw <= '0;
  end

  a_r3_lanes_together: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_dly_rst == '0) || (lane_dly_rst == '1));

  a_r3_pulse_short: assert property (@(posedge clk) disable iff (!rst_n)
    lane_dly_rst[0] |-> ((int'(pw) + 1) * CLK_NS < 50) || (CLK_NS >= 50 && pw == 8'd0));

  a_r2_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lane_dly_rst[0]) |-> $past(&lane_lock) && !$past(&lane_idle) && !$past(restart));

  a_r7_hold_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !restart) |=> done && (lane_dly_rst == '0));

  a_r5_done_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(m_sync_done));

  a_r9_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (failed && !done && !restart) |=> failed && !done);
endmodule

bind rx_align_seq rx_align_seq_chk #(.LANES(LANES), .CLK_NS(CLK_NS)) u_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart), .lane_idle(lane_idle),
  .lane_lock(lane_lock), .lane_dly_rst(lane_dly_rst), .m_sync_done(m_sync_done),
  .done(done), .failed(failed));

// File: tb/rx_align_seq_tb.sv
`timescale 1ns/1ps
module rx_align_seq_tb;
  localparam int L = 4, CLKNS = 20, RC = 3, TMO = 40;

  logic clk = 1'b0, rst_n = 1'b0, restart = 1'b0;
  logic [L-1:0] lane_idle = '1, lane_lock = '0, lane_rst_done = '0;
  logic m_sync_done = 1'b0, m_phalign_done = 1'b0;
  logic [L-1:0] lane_dly_rst;
  logic done, aligned, failed;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  rx_align_seq #(.LANES(L), .CLK_NS(CLKNS), .RST_CYC(RC), .TMO_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .lane_idle(lane_idle),
    .lane_lock(lane_lock), .lane_rst_done(lane_rst_done), .m_sync_done(m_sync_done),
    .m_phalign_done(m_phalign_done), .lane_dly_rst(lane_dly_rst), .done(done),
    .aligned(aligned), .failed(failed));

  function automatic int exp_width(int rc, int cn);
    int lim = 49 / cn;
    int w = (rc < lim) ? rc : lim;
    return (w < 1) ? 1 : w;
  endfunction

  function automatic bit exp_start(logic [L-1:0] idl, logic [L-1:0] lck);
    return (lck == '1) && (idl != '1);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_restart();
    restart = 1'b1; lane_idle = '1; m_sync_done = 1'b0;
    lane_rst_done = '0; m_phalign_done = 1'b0;
    tick(2);
    restart = 1'b0;
    tick(1);
    chk(!done && !failed && lane_dly_rst == '0, "R8", {done, failed}, 0);
  endtask

  task automatic run_seq(bit ph);
    int w = 0;
    lane_idle = 4'b1010; lane_lock = '1;
    tick(1);
    while (lane_dly_rst == '1 && w < 20) begin w++; tick(1); end
    chk(w == exp_width(RC, CLKNS), "R3 width", w, exp_width(RC, CLKNS));
    chk(lane_dly_rst == '0, "R3 same cycle", int'(lane_dly_rst), 0);
    lane_rst_done = 4'b0111;
    tick(2);
    m_sync_done = 1'b1; tick(1); m_sync_done = 1'b0; tick(1);
    chk(!done, "R4 early sync", done, 0);
    lane_rst_done = '1; tick(1);
    m_phalign_done = ph; m_sync_done = 1'b1; tick(1);
    chk(done, "R5", done, 1);
    chk(aligned == ph && failed == !ph, "R6", {aligned, failed}, {ph, !ph});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    tick(3);
    chk(lane_dly_rst == '0 && !done && !aligned && !failed, "R1 in reset", done, 0);
    rst_n = 1'b1; tick(1);
    chk(lane_dly_rst == '0 && !done && !aligned && !failed, "R1 after", done, 0);

    lane_idle = '1; lane_lock = '1; tick(3);
    chk(lane_dly_rst == '0, "R2 all idle", int'(lane_dly_rst), 0);
    lane_idle = 4'b0110; lane_lock = 4'b1110; tick(3);
    chk(lane_dly_rst == '0, "R2 master unlocked", int'(lane_dly_rst), 0);

    run_seq(1'b1);
    m_phalign_done = 1'b0; tick(3);
    chk(aligned && !failed, "R6 hold", aligned, 1);
    for (int i = 0; i < 20; i++) begin
      lane_lock = L'($urandom); lane_idle = L'($urandom); lane_rst_done = L'($urandom);
      m_sync_done = 1'($urandom);
      tick(1);
      chk(done && lane_dly_rst == '0, "R7", int'(lane_dly_rst), 0);
    end
    do_restart();
    run_seq(1'b0);
    do_restart();

    lane_idle = 4'b0111; lane_lock = '1; tick(5);
    tick(TMO + 5);
    chk(failed && !done, "R9 timeout", failed, 1);
    tick(10);
    chk(failed && !done, "R9 sticky", failed, 1);
    do_restart();

    lane_idle = 4'b0000; lane_lock = '1; tick(5);
    lane_rst_done = '1; tick(1);
    lane_lock = 4'b1011; tick(2);
    chk(lane_dly_rst == '0, "R10 lock lost", int'(lane_dly_rst), 0);
    m_sync_done = 1'b1; tick(1);
    chk(!done, "R10 no completion", done, 0);
    m_sync_done = 1'b0; lane_lock = '1; tick(1);
    chk(lane_dly_rst == '1, "R10 restart from idle wait", int'(lane_dly_rst), 15);
    do_restart();
    lane_idle = 4'b1110; lane_lock = '1; tick(1);
    lane_idle = '1; tick(1);
    chk(lane_dly_rst == '0, "R10 all idle", int'(lane_dly_rst), 0);
    tick(3);
    chk(lane_dly_rst == '0 && !done, "R10 stays idle", int'(lane_dly_rst), 0);

    for (int i = 0; i < 150; i++) begin
      logic [L-1:0] ri, rl;
      do_restart();
      ri = L'($urandom);
      rl = ($urandom % 2) ? '1 : L'($urandom);
      lane_idle = ri; lane_lock = rl;
      tick(1);
      chk(lane_dly_rst == (exp_start(ri, rl) ? '1 : '0), "R2 random",
          int'(lane_dly_rst), exp_start(ri, rl) ? 15 : 0);
    end
    do_restart();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule